// File: doc/BRIEF.md
# Straddled Completion Stream Unpacker

This block takes a wide stream of 16-Dword beats. Completion packets are packed into it back to back, and a new packet may begin in the middle of a beat. Packet boundaries are carried only on sideband lines: two start flags with two start-position codes, and two end flags with two last-Dword indices. Each accepted beat is decoded into three per-Dword masks: which Dwords belong to a packet, which one opens a packet and which one closes it. The Dwords that belong to a packet are then replayed one per cycle on a 32-bit output stream, with first and last markers.

A register remembers whether a packet is still open across beats, so the same start code can be read correctly in every beat. Sideband combinations that break the straddling rules raise a sticky error. The offending beat is consumed without output, and the open-packet state is left as it was. The input is held off until every Dword of the current beat has left the output.

Top module: `cplt_straddle_unpack`

## Requirements
- R1: While reset is asserted and right after it is released, out_valid is 0, in_ready is 1 and proto_err is 0, and no packet is open.
- R2: The Dwords of an accepted beat are emitted in ascending lane order. Each Dword appears exactly once, with its data unchanged.
- R3: When no packet is open, a beat must set start flag 0 with position code 2'b00. The packet then begins at lane 0, and that Dword carries out_first.
- R4: When a packet is open and no end flag is set, all 16 lanes are emitted with neither out_first nor out_last.
- R5: A second packet begins at lane 8. This happens when start flag 0 has code 2'b10 while a packet is open, or when start flag 1 has code 2'b10 after a packet began at lane 0. Lanes between the first end and lane 7 are not emitted.
- R6: End flag 0 marks lane in_end0_pos with out_last, and end flag 1 marks lane in_end1_pos. Lanes after the final end in a beat are not emitted. If a packet is left open, emission runs to lane 15.
- R7: in_ready is 0 while any Dword of the accepted beat is still pending. While out_valid=1 and out_ready=0, out_data, out_first and out_last hold their values.
- R8: An accepted beat is illegal, sets proto_err and emits nothing in any of these cases:
  - no start while idle;
  - a start-0 code other than 2'b10 while open, or other than 2'b00 while idle;
  - start 1 set while open, without end 0, or with a code other than 2'b10;
  - a lane-8 start whose end-0 index is 8 or more;
  - end 1 set without end 0, start 0 and a lane-8 start, or with an index below 10.

  An illegal beat leaves the open-packet state unchanged.
- R9: proto_err stays 1 until reset, and legal beats that follow are still unpacked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat valid |
| in_ready | output | 1 | Beat accepted when high together with in_valid |
| in_data | input | 512 | Beat data, lane k at bits 32k+31..32k |
| in_start | input | 2 | Start flags: bit 0 for at least one start, bit 1 for two starts |
| in_start0_pos | input | 2 | Lane code of first start (2'b00 lane 0, 2'b10 lane 8) |
| in_start1_pos | input | 2 | Lane code of second start (2'b10 only) |
| in_end | input | 2 | End flags: bit 0 for at least one end, bit 1 for two ends |
| in_end0_pos | input | 4 | Last-Dword lane of first ending packet |
| in_end1_pos | input | 4 | Last-Dword lane of second ending packet |
| out_valid | output | 1 | Output Dword valid |
| out_ready | input | 1 | Output Dword taken |
| out_data | output | 32 | Output Dword |
| out_first | output | 1 | Dword opens a packet |
| out_last | output | 1 | Dword closes a packet |
| proto_err | output | 1 | Sticky straddle-rule violation |

## Verification
The bench builds the block with its default lane count of 16, a 512-bit beat whose lane 8 is the only mid-beat start point. This gives every placement of a start or end within reach: a single end, a start and an end in one beat, two complete packets in one beat, and an open packet spanning whole beats. Randomly sized packets of 3 to 40 Dwords are packed under randomly chosen straddling with random output stalls. Directed beats cover each illegal sideband pattern, including one sent while a packet is open.

// File: rtl/cpsu_pkg.sv
package cpsu_pkg;
  localparam int unsigned DWORD_W    = 32;
  localparam int unsigned MIN_PKT_DW = 3;   // descriptor length in Dwords

  typedef enum logic [1:0] {
    START_LANE0 = 2'b00,
    START_MID   = 2'b10
  } start_code_e;
endpackage

// File: rtl/cpsu_beat_decode.sv
module cpsu_beat_decode
  import cpsu_pkg::*;
#(
  parameter int unsigned NUM_DW = 16,
  localparam int unsigned PW    = $clog2(NUM_DW)
) (
  input  logic              pkt_open,
  input  logic [1:0]        start,
  input  logic [1:0]        start0_pos,
  input  logic [1:0]        start1_pos,
  input  logic [1:0]        fin,
  input  logic [PW-1:0]     fin0_pos,
  input  logic [PW-1:0]     fin1_pos,
  output logic              illegal,
  output logic              open_nxt,
  output logic [NUM_DW-1:0] vld_mask,
  output logic [NUM_DW-1:0] first_mask,
  output logic [NUM_DW-1:0] last_mask
);
  localparam int unsigned HALF      = NUM_DW / 2;
  localparam int unsigned MIN_END1  = HALF + MIN_PKT_DW - 1;

  logic              mid_start;
  logic [PW-1:0]     a_hi;
  logic [PW-1:0]     b_hi;
  logic [NUM_DW-1:0] vld_raw, first_raw, last_raw;

  // a packet starting at the middle lane: continuation of an open packet
  // ends first, or the lane-0 packet of this beat ends first
  assign mid_start = pkt_open ? start[0] : start[1];

  always_comb begin
    illegal = 1'b0;
    if (start[0] && (start0_pos != (pkt_open ? START_MID : START_LANE0)))
      illegal = 1'b1;
    if (!pkt_open && !start[0])
      illegal = 1'b1;
    if (start[1] && (pkt_open || !fin[0] || (start1_pos != START_MID)))
      illegal = 1'b1;
    if (mid_start && (!fin[0] || (fin0_pos >= PW'(HALF))))
      illegal = 1'b1;
    if (fin[1] && (!fin[0] || !start[0] || !mid_start || (fin1_pos < PW'(MIN_END1))))
      illegal = 1'b1;
  end

  assign a_hi = fin[0] ? fin0_pos : PW'(NUM_DW - 1);
  assign b_hi = fin[1] ? fin1_pos : PW'(NUM_DW - 1);

  for (genvar g = 0; g < NUM_DW; g++) begin : g_lane
    localparam logic [PW-1:0] LANE = PW'(g);
    if (g >= HALF) begin : g_hi
      assign vld_raw[g] = (LANE <= a_hi) || (mid_start && (LANE <= b_hi));
    end else begin : g_lo
      assign vld_raw[g] = (LANE <= a_hi);
    end
    if (g == 0) begin : g_f0
      assign first_raw[g] = !pkt_open;
    end else if (g == HALF) begin : g_fm
      assign first_raw[g] = mid_start;
    end else begin : g_fn
      assign first_raw[g] = 1'b0;
    end
    assign last_raw[g] = (fin[0] && (fin0_pos == LANE)) || (fin[1] && (fin1_pos == LANE));
  end

  assign vld_mask   = illegal ? '0 : vld_raw;
  assign first_mask = illegal ? '0 : first_raw;
  assign last_mask  = illegal ? '0 : last_raw;
  assign open_nxt   = illegal ? pkt_open : (mid_start ? !fin[1] : !fin[0]);
endmodule

// File: rtl/cpsu_dword_seq.sv
module cpsu_dword_seq
  import cpsu_pkg::*;
#(
  parameter int unsigned NUM_DW = 16,
  localparam int unsigned PW     = $clog2(NUM_DW),
  localparam int unsigned BEAT_W = NUM_DW * DWORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [BEAT_W-1:0]  ld_data,
  input  logic [NUM_DW-1:0]  ld_vld,
  input  logic [NUM_DW-1:0]  ld_first,
  input  logic [NUM_DW-1:0]  ld_last,
  output logic               empty,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DWORD_W-1:0] out_data,
  output logic               out_first,
  output logic               out_last
);
  localparam int unsigned HALF = NUM_DW / 2;

  logic [NUM_DW-1:0] pend_q, pend_d;
  logic [NUM_DW-1:0] first_q, last_q;
  logic [BEAT_W-1:0] beat_q;
  logic [PW-1:0]     sel;
  logic              fire;

  always_comb begin
    sel = '0;
    for (int i = NUM_DW - 1; i >= 0; i--) begin
      if (pend_q[i]) sel = PW'(i);
    end
  end

  assign empty     = ~|pend_q;
  assign out_valid = |pend_q;
  assign fire      = out_valid && out_ready;
  assign out_data  = beat_q[int'(sel)*DWORD_W +: DWORD_W];
  assign out_first = first_q[sel];
  assign out_last  = last_q[sel];

  always_comb begin
    pend_d = pend_q;
    if (load)      pend_d = ld_vld;
    else if (fire) pend_d[sel] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      beat_q  <= ld_data;
      first_q <= ld_first;
      last_q  <= ld_last;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_first) && $stable(out_last)));

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !load && (|pend_d)) |=> (out_valid && (sel > $past(sel))));

  p_first_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_first) |-> ((sel == '0) || (sel == PW'(HALF))));
endmodule

// File: rtl/cplt_straddle_unpack.sv
module cplt_straddle_unpack
  import cpsu_pkg::*;
#(
  parameter int unsigned NUM_DW = 16,
  localparam int unsigned PW     = $clog2(NUM_DW),
  localparam int unsigned BEAT_W = NUM_DW * DWORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BEAT_W-1:0]  in_data,
  input  logic [1:0]         in_start,
  input  logic [1:0]         in_start0_pos,
  input  logic [1:0]         in_start1_pos,
  input  logic [1:0]         in_end,
  input  logic [PW-1:0]      in_end0_pos,
  input  logic [PW-1:0]      in_end1_pos,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DWORD_W-1:0] out_data,
  output logic               out_first,
  output logic               out_last,
  output logic               proto_err
);
  logic              open_q, open_d, open_nxt;
  logic              err_q, err_d;
  logic              illegal, accept, seq_empty;
  logic [NUM_DW-1:0] vld_mask, first_mask, last_mask;

  cpsu_beat_decode #(.NUM_DW(NUM_DW)) u_decode (
    .pkt_open   (open_q),
    .start      (in_start),
    .start0_pos (in_start0_pos),
    .start1_pos (in_start1_pos),
    .fin        (in_end),
    .fin0_pos   (in_end0_pos),
    .fin1_pos   (in_end1_pos),
    .illegal    (illegal),
    .open_nxt   (open_nxt),
    .vld_mask   (vld_mask),
    .first_mask (first_mask),
    .last_mask  (last_mask)
  );

  cpsu_dword_seq #(.NUM_DW(NUM_DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .ld_data   (in_data),
    .ld_vld    (vld_mask),
    .ld_first  (first_mask),
    .ld_last   (last_mask),
    .empty     (seq_empty),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_first (out_first),
    .out_last  (out_last)
  );

  assign in_ready  = seq_empty;
  assign accept    = in_valid && in_ready;
  assign proto_err = err_q;

  always_comb begin
    open_d = open_q;
    err_d  = err_q;
    if (accept) begin
      open_d = open_nxt;
      err_d  = err_q | illegal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      open_q <= open_d;
      err_q  <= err_d;
    end
  end

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  p_err_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && illegal) |=> (!out_valid && proto_err));

  p_err_keeps_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && illegal) |=> (open_q == $past(open_q)));
endmodule

// File: tb/cplt_straddle_unpack_tb_top.sv
module cplt_straddle_unpack_tb_top;
  localparam int NDW  = 16;
  localparam int DW   = 32;
  localparam int HALF = NDW / 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid, in_ready, out_valid, out_ready;
  logic [NDW*DW-1:0] in_data;
  logic [1:0]        in_start, in_start0_pos, in_start1_pos, in_end;
  logic [3:0]        in_end0_pos, in_end1_pos;
  logic [DW-1:0]     out_data;
  logic              out_first, out_last, proto_err;

  int n_chk = 0, n_fail = 0;
  int rdy_pct = 100;
  logic [DW+1:0] exp_q[$];
  int len_q[$];

  always #4 clk = ~clk;

  cplt_straddle_unpack #(.NUM_DW(NDW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_start(in_start), .in_start0_pos(in_start0_pos),
    .in_start1_pos(in_start1_pos), .in_end(in_end), .in_end0_pos(in_end0_pos),
    .in_end1_pos(in_end1_pos), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_first(out_first), .out_last(out_last),
    .proto_err(proto_err));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [DW+1:0] pack_exp(logic [DW-1:0] d, bit f, bit l);
    return {f, l, d};
  endfunction

  // monitor: choose out_ready and compare a transfer that will occur at next edge
  initial begin
    logic [DW+1:0] held;
    bit stalled = 0;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        automatic bit r = ($urandom % 100) < rdy_pct;
        if (stalled)
          check(out_valid && {out_first, out_last, out_data} == held, "R7", "held output",
                {out_first, out_last, out_data}, held);
        if (out_valid)
          check(!in_ready, "R7", "in_ready while pending", in_ready, 0);
        out_ready = r;
        stalled = out_valid && !r;
        held = {out_first, out_last, out_data};
        if (out_valid && r) begin
          if (exp_q.size() == 0)
            check(0, "R2", "unexpected Dword", {out_first, out_last, out_data}, 0);
          else begin
            automatic logic [DW+1:0] e = exp_q.pop_front();
            check({out_first, out_last, out_data} == e, "R2/R3/R4/R5/R6", "Dword",
                  {out_first, out_last, out_data}, e);
          end
        end
      end else stalled = 0;
    end
  end

  task automatic drive_beat(input logic [NDW*DW-1:0] d, input logic [1:0] s,
                            input logic [1:0] s0p, input logic [1:0] s1p,
                            input logic [1:0] e, input logic [3:0] e0p,
                            input logic [3:0] e1p);
    in_data = d; in_start = s; in_start0_pos = s0p; in_start1_pos = s1p;
    in_end = e; in_end0_pos = e0p; in_end1_pos = e1p;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [NDW*DW-1:0] rand_beat();
    logic [NDW*DW-1:0] d;
    for (int k = 0; k < NDW; k++) d[k*DW +: DW] = $urandom;
    return d;
  endfunction

  // pack the lengths in len_q into straddled beats, filling the expected queue
  task automatic stream(input int straddle_pct, input int gap_pct);
    int rem = 0;
    while (len_q.size() > 0 || rem > 0) begin
      logic [NDW*DW-1:0] d = rand_beat();
      logic [1:0] s = 0, s0p = 0, s1p = 0, e = 0;
      logic [3:0] e0p = 0, e1p = 0;
      int pos, n;
      bit was_open = (rem > 0);
      bit fresh = !was_open;
      if (fresh) begin
        rem = len_q.pop_front();
        s[0] = 1'b1; s0p = 2'b00;
      end
      n = (rem < NDW) ? rem : NDW;
      for (int k = 0; k < n; k++) begin
        exp_q.push_back(pack_exp(d[k*DW +: DW], fresh && k == 0, rem == 1));
        rem--;
      end
      if (rem == 0) begin e[0] = 1'b1; e0p = 4'(n - 1); pos = n; end
      else pos = NDW;
      if (pos <= HALF && len_q.size() > 0 && ($urandom % 100) < straddle_pct) begin
        rem = len_q.pop_front();
        if (was_open) begin s[0] = 1'b1; s0p = 2'b10; end
        else begin s[1] = 1'b1; s1p = 2'b10; end
        n = (rem < HALF) ? rem : HALF;
        for (int k = 0; k < n; k++) begin
          exp_q.push_back(pack_exp(d[(HALF+k)*DW +: DW], k == 0, rem == 1));
          rem--;
        end
        if (rem == 0) begin e[1] = 1'b1; e1p = 4'(HALF + n - 1); end
      end
      drive_beat(d, s, s0p, s1p, e, e0p, e1p);
      while (($urandom % 100) < gap_pct) @(negedge clk);
    end
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 2000 && (exp_q.size() > 0 || out_valid); i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, req, "expected Dwords left", exp_q.size(), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    in_data = '0; in_start = 0; in_start0_pos = 0; in_start1_pos = 0;
    in_end = 0; in_end0_pos = 0; in_end1_pos = 0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready && !proto_err, "R1", "reset outputs",
          {out_valid, in_ready, proto_err}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready && !proto_err, "R1", "after release",
          {out_valid, in_ready, proto_err}, 3'b010);
  endtask

  task automatic bad_beat(input string tag, input logic [1:0] s, input logic [1:0] s0p,
                          input logic [1:0] s1p, input logic [1:0] e,
                          input logic [3:0] e0p, input logic [3:0] e1p);
    do_reset();
    drive_beat(rand_beat(), s, s0p, s1p, e, e0p, e1p);
    repeat (20) @(negedge clk);
    check(proto_err == 1'b1, "R8", tag, proto_err, 1);
    check(exp_q.size() == 0 && !out_valid, "R8", {tag, " silent"}, out_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    void'($urandom(32'd20241));
    do_reset();

    // four packets straddled as in a typical dense burst (R5, R6)
    len_q = '{22, 7, 4, 3};
    stream(100, 0);
    drain("R5");
    // exact-fit, long (whole-beat continuation, R4) and non-straddled
    len_q = '{16, 40, 8, 3, 35, 5};
    stream(0, 20);
    drain("R4");
    len_q = '{16, 40, 8, 3, 35, 5, 3, 3};
    stream(100, 0);
    drain("R6");
    check(!proto_err, "R8", "legal stream no error", proto_err, 0);

    // random packing with stalls
    rdy_pct = 60;
    for (int i = 0; i < 300; i++) len_q.push_back(3 + ($urandom % 38));
    stream(70, 15);
    drain("R2");
    check(!proto_err, "R8", "random stream no error", proto_err, 0);
    rdy_pct = 100;

    // illegal sideband patterns
    bad_beat("no start idle", 2'b00, 2'b00, 2'b00, 2'b01, 4'd3, 4'd0);
    len_q = '{5};
    stream(0, 0);
    drain("R9");
    check(proto_err, "R9", "error sticky", proto_err, 1);
    bad_beat("start0 code 01", 2'b01, 2'b01, 2'b00, 2'b01, 4'd15, 4'd0);
    bad_beat("start0 code 10 idle", 2'b01, 2'b10, 2'b00, 2'b01, 4'd12, 4'd0);
    bad_beat("start1 no end0", 2'b11, 2'b00, 2'b10, 2'b00, 4'd0, 4'd0);
    bad_beat("end1 below 10", 2'b11, 2'b00, 2'b10, 2'b11, 4'd4, 4'd9);
    bad_beat("end1 no start1", 2'b01, 2'b00, 2'b00, 2'b11, 4'd5, 4'd12);
    bad_beat("start1 code 00", 2'b11, 2'b00, 2'b00, 2'b01, 4'd4, 4'd0);

    // illegal beat while open keeps the open packet (R8)
    do_reset();
    begin
      logic [NDW*DW-1:0] d = rand_beat();
      for (int k = 0; k < NDW; k++) exp_q.push_back(pack_exp(d[k*DW +: DW], k == 0, 0));
      drive_beat(d, 2'b01, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0);
      drive_beat(rand_beat(), 2'b01, 2'b00, 2'b00, 2'b01, 4'd3, 4'd0);
      d = rand_beat();
      for (int k = 0; k < 4; k++) exp_q.push_back(pack_exp(d[k*DW +: DW], 0, k == 3));
      drive_beat(d, 2'b00, 2'b00, 2'b00, 2'b01, 4'd3, 4'd0);
    end
    drain("R8");
    check(proto_err, "R8", "open-state error flagged", proto_err, 1);

    report();
  end
endmodule